// File: doc/BRIEF.md
# Three-Level Space Vector Dwell-Time Calculator

This block turns one sampled reference voltage vector into the application times of the vectors that make it up, for a three-level space vector modulator. It takes an absolute angle and splits it into a 60-degree sector index and a local angle inside that sector. It splits the reference magnitude into two components, one along each adjacent active vector. The second component uses the sine of the local angle. The first uses the sine of thirty degrees minus the local angle. Each component is divided by the adjacent-vector magnitude and scaled by the half switching period Tc, given in clock ticks. The full period is 2·Tc. Whatever is left of Tc goes to the null vector.

The modulator asserts a start strobe with the operands. The block then works through a fixed sequence using one shared multiplier and a one-bit-per-cycle divider. When the three dwell counts and the sector are ready, it raises done for one cycle. The outputs hold their values until the next result. The sine values come from an internal table of the first sixty degrees, filled in at elaboration.

Top module: `svm3_dwell`

## Requirements
- R1: While reset is asserted, and after it until the first result, done is low and sector, dwell_a, dwell_b and dwell_null are all zero.
- R2: The 9-bit angle counts steps of 60/64 degree. Values 384 to 511 wrap to the angle minus 384. The sector is the wrapped angle divided by 64 (0 to 5), and the local step k is the wrapped angle modulo 64.
- R3: Sine values are S(k) = round(sin(k·60/64 degrees)·32768), an unsigned fraction with 15 fractional bits.
- R4: dwell_b = floor(m·S(k)·Tc / (adj_mag·16384)), where m is the effective reference magnitude of R11. This is twice the reference times sin(theta), divided by the adjacent magnitude and scaled by Tc.
- R5: For k ≤ 32, dwell_a = floor(m·S(32−k)·Tc / (adj_mag·16384)), which uses sin(30° − theta). For k > 32 the first component is taken as zero.
- R6: When the unscaled dwell_a + dwell_b ≤ Tc, dwell_null = Tc − dwell_a − dwell_b.
- R7: When the unscaled sum exceeds Tc, the results are scaled: dwell_a = floor(a·Tc/(a+b)), dwell_b = Tc − dwell_a, and dwell_null = 0.
- R8: An adj_mag of zero gives dwell_a = dwell_b = 0 and dwell_null = Tc.
- R9: done is high for exactly one cycle, 40 clock edges after the edge that accepts start, or 58 edges after it when R7 scaling applies. All four result outputs change on that same edge and hold their values at every other time.
- R10: A start seen on any edge while a computation is in progress, including the edge on which done rises, is ignored. A start seen in the cycle while done is high is accepted.
- R11: The effective reference magnitude m is the smaller of ref_mag and adj_mag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation with the operands present |
| angle | input | 9 | Absolute reference angle in steps of 60/64 degree |
| ref_mag | input | 16 | Reference vector magnitude |
| adj_mag | input | 16 | Adjacent active vector magnitude |
| half_period | input | 16 | Tc in clock ticks |
| done | output | 1 | One-cycle result strobe |
| sector | output | 3 | Sector index 0..5 |
| dwell_a | output | 16 | Ticks for the first adjacent vector |
| dwell_b | output | 16 | Ticks for the second adjacent vector |
| dwell_null | output | 16 | Ticks for the null vector |

## Verification
A fault in the sequencer shows up at the ports on the next result. A skipped or extra divide step either moves the done pulse away from edge 40 or 58, or corrupts a quotient bit. A wrong remainder or table entry shows up as a dwell count that differs from the bench's integer arithmetic. A bad operand latch shows up when a start is given mid-computation: the pending result is altered or the request is taken. Because every output is compared on every cycle, a wrong value is reported at the first cycle in which it becomes visible.

// File: rtl/svm3_dwell.sv
module svm3_dwell #(
  parameter int TW       = 16,
  parameter int LOC_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LOC_BITS+2:0]   angle,
  input  logic [TW-1:0]         ref_mag,
  input  logic [TW-1:0]         adj_mag,
  input  logic [TW-1:0]         half_period,
  output logic                  done,
  output logic [2:0]            sector,
  output logic [TW-1:0]         dwell_a,
  output logic [TW-1:0]         dwell_b,
  output logic [TW-1:0]         dwell_null
);
  localparam int QW   = TW + 1;
  localparam int FRAC = TW - 1;
  localparam int NW   = 3 * TW;
  localparam int RW   = NW - QW;
  localparam int NLOC = 2 ** LOC_BITS;
  localparam int HALF = NLOC / 2;
  localparam int CW   = $clog2(QW + 1);

  typedef enum logic [3:0] {S_IDLE, S_MA1, S_MB1, S_DV1, S_MA2, S_MB2, S_DV2,
                            S_CHK, S_MS, S_DVS, S_FIN} st_t;

  function automatic logic [TW-1:0] sine_q(input int k);
    real rad;
    rad = 3.14159265358979 * k / (3.0 * (2.0 ** LOC_BITS));
    return TW'($rtoi($sin(rad) * (2.0 ** FRAC) + 0.5));
  endfunction

  logic [TW-1:0] rom [NLOC];
  for (genvar g = 0; g < NLOC; g++) begin : g_rom
    assign rom[g] = sine_q(g);
  end

  st_t                 st;
  logic [2:0]          sec_r;
  logic [LOC_BITS-1:0] loc_r;
  logic [TW-1:0]       mag_r, adj_r, tc_r;
  logic [2*TW-1:0]     p_r;
  logic [RW-1:0]       rem_r, den_r;
  logic [QW-1:0]       lo_r, ta_r, tb_r;
  logic [CW-1:0]       cnt_r;

  logic [2:0]          raw_sec;
  logic [2*TW-1:0]     mul_a;
  logic [TW-1:0]       mul_b, s_a, s_b;
  logic [NW-1:0]       prod;
  logic [RW:0]         trial;
  logic                ge;
  logic [RW-1:0]       rem_nx;
  logic [QW-1:0]       q_nx;
  logic [QW:0]         sum_ab;
  logic                last;

  assign raw_sec = angle[LOC_BITS+2:LOC_BITS];
  assign s_a     = (int'(loc_r) <= HALF) ? rom[LOC_BITS'(HALF - int'(loc_r))] : '0;
  assign s_b     = rom[loc_r];

  always_comb begin
    mul_a = {{TW{1'b0}}, mag_r};
    mul_b = s_a;
    case (st)
      S_MA2:        mul_b = s_b;
      S_MB1, S_MB2: begin mul_a = p_r; mul_b = tc_r; end
      S_MS:         begin mul_a = (2*TW)'(ta_r); mul_b = tc_r; end
      default: ;
    endcase
  end

  assign prod   = NW'(mul_a) * NW'(mul_b);
  assign trial  = {rem_r, lo_r[QW-1]};
  assign ge     = (den_r != '0) && (trial >= {1'b0, den_r});
  assign rem_nx = ge ? RW'(trial - {1'b0, den_r}) : trial[RW-1:0];
  assign q_nx   = {lo_r[QW-2:0], ge};
  assign sum_ab = {1'b0, ta_r} + {1'b0, tb_r};
  assign last   = (cnt_r == CW'(QW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sec_r <= '0; loc_r <= '0; mag_r <= '0; adj_r <= '0; tc_r <= '0;
      p_r <= '0; rem_r <= '0; den_r <= '0; lo_r <= '0; cnt_r <= '0;
      ta_r <= '0; tb_r <= '0;
      done <= 1'b0; sector <= '0;
      dwell_a <= '0; dwell_b <= '0; dwell_null <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sec_r <= (raw_sec >= 3'd6) ? raw_sec - 3'd6 : raw_sec;
          loc_r <= angle[LOC_BITS-1:0];
          mag_r <= (ref_mag > adj_mag) ? adj_mag : ref_mag;
          adj_r <= adj_mag;
          tc_r  <= half_period;
          st    <= S_MA1;
        end
        S_MA1, S_MA2: begin
          p_r <= prod[2*TW-1:0];
          st  <= (st == S_MA1) ? S_MB1 : S_MB2;
        end
        S_MB1, S_MB2, S_MS: begin
          rem_r <= prod[NW-1:QW];
          lo_r  <= prod[QW-1:0];
          den_r <= (st == S_MS) ? RW'(sum_ab) : RW'({adj_r, {(FRAC-1){1'b0}}});
          cnt_r <= '0;
          st    <= (st == S_MB1) ? S_DV1 : (st == S_MB2) ? S_DV2 : S_DVS;
        end
        S_DV1, S_DV2, S_DVS: begin
          rem_r <= rem_nx;
          lo_r  <= q_nx;
          cnt_r <= cnt_r + 1'b1;
          if (last) begin
            if (st == S_DV1) begin
              ta_r <= q_nx; st <= S_MA2;
            end else if (st == S_DV2) begin
              tb_r <= q_nx; st <= S_CHK;
            end else begin
              ta_r <= q_nx; tb_r <= QW'({1'b0, tc_r} - q_nx); st <= S_FIN;
            end
          end
        end
        S_CHK: st <= (sum_ab > (QW+1)'(tc_r)) ? S_MS : S_FIN;
        S_FIN: begin
          dwell_a    <= ta_r[TW-1:0];
          dwell_b    <= tb_r[TW-1:0];
          dwell_null <= TW'((QW+1)'(tc_r) - sum_ab);
          sector     <= sec_r;
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  dwell_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((QW+1)'(dwell_a) + (QW+1)'(dwell_b) + (QW+1)'(dwell_null) == (QW+1)'(tc_r)));

  // R2
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector < 3'd6);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(tc_r) && $stable(mag_r) && $stable(loc_r)));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ##1 (!done || $past(st == S_FIN)));
endmodule

// File: tb/svm3_dwell_bench.sv
module svm3_dwell_bench;
  localparam int PER = 10;
  localparam int QW  = 17;
  localparam int LAT_PLAIN = 6 + 2 * QW;
  localparam int LAT_SCALE = 7 + 3 * QW;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [8:0]  angle = '0;
  logic [15:0] ref_mag = '0, adj_mag = '0, half_period = '0;
  logic        done;
  logic [2:0]  sector;
  logic [15:0] dwell_a, dwell_b, dwell_null;

  svm3_dwell u_svm3_dwell (
    .clk(clk), .rst_n(rst_n), .start(start), .angle(angle),
    .ref_mag(ref_mag), .adj_mag(adj_mag), .half_period(half_period),
    .done(done), .sector(sector), .dwell_a(dwell_a), .dwell_b(dwell_b),
    .dwell_null(dwell_null));

  always #(PER/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit fin = 0, cmp_en = 0;

  longint m_cnt = 0, m_done = 0, m_sec = 0, m_a = 0, m_b = 0, m_n = 0;
  longint p_sec, p_a, p_b, p_n, p_lat;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R3
  function automatic longint sine_ref(input longint k);
    real r;
    r = $sin(3.14159265358979 * k / 192.0) * 32768.0 + 0.5;
    return longint'($rtoi(r));
  endfunction

  task automatic predict(input longint ang, input longint mag, input longint adj, input longint tc);
    longint a, k, m, sa, sb, t1, t2, n1;
    a = (ang >= 384) ? ang - 384 : ang;
    k = a % 64;
    p_sec = a / 64;
    m  = (mag > adj) ? adj : mag;                 // R11
    sa = (k <= 32) ? sine_ref(32 - k) : 0;        // R5
    sb = sine_ref(k);                             // R4
    t1 = (adj == 0) ? 0 : (m * sa * tc) / (adj * 16384);
    t2 = (adj == 0) ? 0 : (m * sb * tc) / (adj * 16384);
    if (t1 + t2 > tc) begin                       // R7
      n1 = (t1 * tc) / (t1 + t2);
      p_a = n1; p_b = tc - n1; p_n = 0; p_lat = LAT_SCALE;
    end else begin                                // R6
      p_a = t1; p_b = t2; p_n = tc - t1 - t2; p_lat = LAT_PLAIN;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_sec = 0; m_a = 0; m_b = 0; m_n = 0;
    end else begin
      m_done = 0;
      if (m_cnt != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_sec = p_sec; m_a = p_a; m_b = p_b; m_n = p_n;
        end
      end else if (start) begin                   // R10: only taken when idle
        predict(angle, ref_mag, adj_mag, half_period);
        m_cnt = p_lat;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R9 done", done, m_done);
      chk("R2 sector", sector, m_sec);
      chk("R5 dwell_a", dwell_a, m_a);
      chk("R4 dwell_b", dwell_b, m_b);
      chk("R6 dwell_null", dwell_null, m_n);
    end
  end

  task automatic issue(input int ang, input int mag, input int adj, input int tc);
    @(negedge clk);
    angle = 9'(ang); ref_mag = 16'(mag); adj_mag = 16'(adj); half_period = 16'(tc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic run(input int ang, input int mag, input int adj, input int tc);
    issue(ang, mag, adj, tc);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 done", done, 0);
    chk("R1 sector", sector, 0);
    chk("R1 dwell_a", dwell_a, 0);
    chk("R1 dwell_b", dwell_b, 0);
    chk("R1 dwell_null", dwell_null, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (3) @(negedge clk);

    // R5: theta = 0, full magnitude -> first vector takes all of Tc
    run(0, 1000, 1000, 500);
    chk("R5 direct a", dwell_a, 500);
    chk("R5 direct b", dwell_b, 0);
    // R7: theta = 15 deg at full magnitude overflows slightly
    run(64 + 16, 4000, 4000, 1000);
    chk("R7 direct null", dwell_null, 0);
    // R7: k > 32, first component zero, second saturates
    run(2*64 + 48, 3000, 3000, 800);
    chk("R7 direct a", dwell_a, 0);
    chk("R7 direct b", dwell_b, 800);
    chk("R2 direct sector", sector, 2);
    // R6 normal case
    run(5*64 + 10, 300, 1000, 1000);
    // R11 reference above adjacent magnitude
    run(3*64 + 5, 5000, 2000, 700);
    // R8 zero adjacent magnitude
    run(4*64 + 20, 100, 0, 900);
    chk("R8 direct null", dwell_null, 900);
    chk("R8 direct a", dwell_a, 0);
    // R2 wrap
    run(400, 500, 900, 600);
    chk("R2 wrap sector", sector, 0);
    run(511, 500, 900, 600);
    chk("R2 wrap sector top", sector, 1);
    // R4 extreme operands, k = 32
    run(32, 65535, 65535, 65535);
    chk("R4 direct b", dwell_b, 65535);
    chk("R4 direct a", dwell_a, 0);

    // R10: start during busy is ignored
    issue(64 + 3, 1200, 1500, 400);
    repeat (10) @(negedge clk);
    angle = 9'd200; ref_mag = 16'd1; adj_mag = 16'd7; half_period = 16'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R10: start held until done, then accepted back to back
    issue(2*64 + 7, 800, 1000, 3000);
    start = 1'b1;
    angle = 9'd300; ref_mag = 16'd900; adj_mag = 16'd950; half_period = 16'd2500;
    while (m_done == 0) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    for (int i = 0; i < 40; i++) begin
      run(int'($urandom % 512), int'($urandom % 65536), int'($urandom % 65536),
          int'($urandom % 65536));
    end
    repeat (3) @(negedge clk);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PER * 100000);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule